// File: doc/BRIEF.md
# Synchronous DRAM Write Burst Engine

This block is the write path on the device side of a synchronous DRAM. It decodes the four active-low command strobes on every rising clock edge. When a WRITE command arrives, it takes in the bank select, the starting column and the auto-precharge flag. From then on it produces one array write per clock edge. Each write carries a column address, a bank, the data word sampled on that edge and per-byte write enables. The write for the command's own data is captured on the same edge as the command, and every later word is captured on the edges that follow.

The burst length is fixed when the block is built. It is either 1, 2, 4 or 8 words, which step through an aligned column block, or a full page, which steps through every column, wraps to zero and only stops when another command arrives. A new WRITE on any cycle cuts the running burst short at once and starts its own burst. When a fixed-length burst finishes with auto precharge set, the block sends out a one-cycle precharge request for that bank. A byte mask removes individual lanes from a write, but the column still advances.

All outputs are registered. The write caused by a clock edge becomes visible in the cycle that follows that edge. The array that receives the writes sits outside the block.

Top module: `sdwr_burst_engine`

## Requirements
- R1: A synchronous active-low reset clears the engine. In the cycle after a reset edge, `wr_slot`, `wr_en` and `pre_req` are all 0, and the next NOP produces no write.
- R2: Command decoding uses the pin order (sel_n, rowstb_n, colstb_n, wrstb_n). WRITE is 0,1,0,0 and NOP is 0,1,1,1. A deselect, with sel_n at 1, is treated like a NOP: a running burst keeps going through it.
- R3: A WRITE edge produces a write in the next cycle. That write uses column `addr_in[COL_W-1:0]`, bank `bank_in` and the `din` value sampled on the same edge.
- R4: In a fixed burst of length BL = 2^BURST_CODE, each following edge writes the next column. Only the low log2(BL) column bits count up, and they wrap inside the aligned block.
- R5: Once BL words have been written, or while no burst is running, NOP and deselect edges produce no write, and `din` is ignored.
- R6: A WRITE with `addr_in[AP_BIT]` at 1 (bit 10 by default) makes `pre_req` pulse high for one cycle, at the same time as the burst's final write, with `pre_bank` equal to the burst's bank. With that bit at 0, no request is made.
- R7: With BURST_CODE = 4 (full page), the column counts up modulo 2^COL_W without end and no precharge request is ever made.
- R8: A WRITE that arrives while a burst is running ends the old burst at once. The data on that edge goes to the new burst, and the truncated burst makes no precharge request.
- R9: Any other command with sel_n at 0 (neither NOP nor WRITE) ends a running burst. That edge produces no write and no precharge request.
- R10: On each write, `wr_en[i]` equals the inverse of `byte_mask[i]`. A masked lane still uses up its column step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Chip select strobe, active low |
| rowstb_n | input | 1 | Row strobe, active low |
| colstb_n | input | 1 | Column strobe, active low |
| wrstb_n | input | 1 | Write strobe, active low |
| addr_in | input | ADDR_W | Address pins: column in the low bits, auto-precharge flag at AP_BIT |
| bank_in | input | BANK_W | Bank select |
| din | input | DATA_W | Write data sampled on each edge |
| byte_mask | input | DATA_W/8 | Per-byte mask, 1 suppresses that lane |
| wr_slot | output | 1 | A burst word occupies this cycle |
| wr_en | output | DATA_W/8 | Per-byte write enables to the array |
| wr_bank | output | BANK_W | Bank of the current write |
| wr_col | output | COL_W | Column of the current write |
| wr_data | output | DATA_W | Data of the current write |
| pre_req | output | 1 | One-cycle precharge request |
| pre_bank | output | BANK_W | Bank to precharge |

## Verification
The assertions assume that the command strobes, the address, the bank and the mask hold known values at every rising edge while reset is released. They also assume that the mask belongs to the same edge as its data word. The stimulus changes every input only on the falling clock edge and draws each value from a defined range, so every sample at a rising edge is stable and never X. Random traffic mixes WRITEs, NOPs, deselects, other commands and occasional resets in a fixed ratio. Directed sequences cover in-block wrap, page wrap, truncation and masked lanes.

// File: rtl/sdwr_pkg.sv
package sdwr_pkg;

    // Decoded command classes seen by the write engine
    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_NOP   = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_OTHER = 2'd3
    } cmd_e;

    // BURST_CODE value that selects full-page operation
    localparam int BURST_FULL = 4;

endpackage

// File: rtl/sdwr_cmd_decode.sv
module sdwr_cmd_decode
    import sdwr_pkg::*;
(
    input  logic sel_n,
    input  logic rowstb_n,
    input  logic colstb_n,
    input  logic wrstb_n,
    output cmd_e cmd
);

    always_comb begin
        if (sel_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({rowstb_n, colstb_n, wrstb_n})
                3'b100:  cmd = CMD_WRITE;
                3'b111:  cmd = CMD_NOP;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/sdwr_col_step.sv
module sdwr_col_step #(
    parameter int COL_W  = 8,
    parameter int LOG_BL = 2,
    parameter bit FULL   = 1'b0
) (
    input  logic [COL_W-1:0] cur,
    output logic [COL_W-1:0] nxt
);

    generate
        if (FULL) begin : g_page
            // whole column field counts, wrapping at the end of the page
            assign nxt = cur + 1'b1;
        end else if (LOG_BL == 0) begin : g_single
            assign nxt = cur;
        end else begin : g_block
            // only the in-block bits count; the block base is held
            logic [LOG_BL-1:0] low_inc;
            assign low_inc = cur[LOG_BL-1:0] + 1'b1;
            assign nxt     = {cur[COL_W-1:LOG_BL], low_inc};
        end
    endgenerate

endmodule

// File: rtl/sdwr_lane_gate.sv
module sdwr_lane_gate #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] mask,
    output logic [LANES-1:0] en
);

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign en[i] = ~mask[i];
        end
    endgenerate

endmodule

// File: rtl/sdwr_burst_engine.sv
module sdwr_burst_engine
    import sdwr_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int COL_W      = 8,
    parameter int BANK_W     = 2,
    parameter int ADDR_W     = 12,
    parameter int AP_BIT     = 10,
    parameter int BURST_CODE = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_n,
    input  logic                   rowstb_n,
    input  logic                   colstb_n,
    input  logic                   wrstb_n,
    input  logic [ADDR_W-1:0]      addr_in,
    input  logic [BANK_W-1:0]      bank_in,
    input  logic [DATA_W-1:0]      din,
    input  logic [DATA_W/8-1:0]    byte_mask,
    output logic                   wr_slot,
    output logic [DATA_W/8-1:0]    wr_en,
    output logic [BANK_W-1:0]      wr_bank,
    output logic [COL_W-1:0]       wr_col,
    output logic [DATA_W-1:0]      wr_data,
    output logic                   pre_req,
    output logic [BANK_W-1:0]      pre_bank
);

    localparam bit FULL    = (BURST_CODE == BURST_FULL);
    localparam int LOG_BL  = FULL ? COL_W : BURST_CODE;
    localparam int LANES   = DATA_W / 8;
    localparam int LEFT_W  = 4;
    localparam logic [LEFT_W-1:0] LAST_CNT = LEFT_W'((1 << (FULL ? 0 : BURST_CODE)) - 1);

    typedef struct packed {
        logic              active;
        logic              ap;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [LEFT_W-1:0] left;
        logic              slot;
        logic [LANES-1:0]  en;
        logic [COL_W-1:0]  wcol;
        logic [BANK_W-1:0] wbank;
        logic [DATA_W-1:0] wdata;
        logic              pre;
        logic [BANK_W-1:0] pbank;
    } eng_t;

    eng_t q, d;

    cmd_e             cmd;
    logic [COL_W-1:0] start_col;
    logic [COL_W-1:0] start_next;
    logic [COL_W-1:0] run_next;
    logic [LANES-1:0] lane_en;
    logic             burst_on;
    logic             unused_addr;

    assign start_col   = addr_in[COL_W-1:0];
    assign unused_addr = ^addr_in;
    assign burst_on    = q.active;

    sdwr_cmd_decode u_dec (
        .sel_n    (sel_n),
        .rowstb_n (rowstb_n),
        .colstb_n (colstb_n),
        .wrstb_n  (wrstb_n),
        .cmd      (cmd)
    );

    sdwr_col_step #(.COL_W(COL_W), .LOG_BL(LOG_BL), .FULL(FULL)) u_step_new (
        .cur (start_col),
        .nxt (start_next)
    );

    sdwr_col_step #(.COL_W(COL_W), .LOG_BL(LOG_BL), .FULL(FULL)) u_step_run (
        .cur (q.col),
        .nxt (run_next)
    );

    sdwr_lane_gate #(.LANES(LANES)) u_lanes (
        .mask (byte_mask),
        .en   (lane_en)
    );

    always_comb begin
        d      = q;
        d.slot = 1'b0;
        d.en   = '0;
        d.pre  = 1'b0;
        unique case (cmd)
            CMD_WRITE: begin
                // new burst; any running one is dropped, including its precharge
                d.slot   = 1'b1;
                d.en     = lane_en;
                d.wcol   = start_col;
                d.wbank  = bank_in;
                d.wdata  = din;
                d.bank   = bank_in;
                d.ap     = addr_in[AP_BIT];
                d.col    = start_next;
                d.left   = LAST_CNT;
                d.active = FULL || (LAST_CNT != '0);
                if (!FULL && (LAST_CNT == '0) && addr_in[AP_BIT]) begin
                    d.pre   = 1'b1;
                    d.pbank = bank_in;
                end
            end
            CMD_NOP, CMD_DESEL: begin
                if (q.active) begin
                    d.slot  = 1'b1;
                    d.en    = lane_en;
                    d.wcol  = q.col;
                    d.wbank = q.bank;
                    d.wdata = din;
                    d.col   = run_next;
                    if (!FULL) begin
                        d.left = q.left - 1'b1;
                        if (q.left == LEFT_W'(1)) begin
                            d.active = 1'b0;
                            if (q.ap) begin
                                d.pre   = 1'b1;
                                d.pbank = q.bank;
                            end
                        end
                    end
                end
            end
            default: begin
                d.active = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_slot  = q.slot;
    assign wr_en    = q.en;
    assign wr_bank  = q.wbank;
    assign wr_col   = q.wcol;
    assign wr_data  = q.wdata;
    assign pre_req  = q.pre;
    assign pre_bank = q.pbank;

endmodule

// File: rtl/sdwr_burst_chk.sv
module sdwr_burst_chk #(
    parameter int DATA_W = 16,
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sel_n,
    input logic                rowstb_n,
    input logic                colstb_n,
    input logic                wrstb_n,
    input logic [ADDR_W-1:0]   addr_in,
    input logic [BANK_W-1:0]   bank_in,
    input logic [DATA_W/8-1:0] byte_mask,
    input logic                burst_on,
    input logic                wr_slot,
    input logic [DATA_W/8-1:0] wr_en,
    input logic [BANK_W-1:0]   wr_bank,
    input logic [COL_W-1:0]    wr_col,
    input logic                pre_req,
    input logic [BANK_W-1:0]   pre_bank
);

    logic is_write;
    logic is_other;
    logic unused_hi;

    assign is_write  = !sel_n && rowstb_n && !colstb_n && !wrstb_n;
    assign is_other  = !sel_n && !is_write && !(rowstb_n && colstb_n && wrstb_n);
    assign unused_hi = ^addr_in;

    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!wr_slot && !pre_req && wr_en == '0));

    a_r3_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        is_write |=> (wr_slot && wr_col == $past(addr_in[COL_W-1:0]) && wr_bank == $past(bank_in)));

    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_on && !is_write) |=> !wr_slot);

    a_r6_pre_with_last: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req |-> (wr_slot && pre_bank == wr_bank));

    a_r9_other_stops: assert property (@(posedge clk) disable iff (!rst_n)
        is_other |=> (!wr_slot && !pre_req));

    a_r10_lane_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_slot |-> (wr_en == ~$past(byte_mask)));

endmodule

bind sdwr_burst_engine sdwr_burst_chk #(
    .DATA_W (DATA_W),
    .COL_W  (COL_W),
    .BANK_W (BANK_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .rowstb_n  (rowstb_n),
    .colstb_n  (colstb_n),
    .wrstb_n   (wrstb_n),
    .addr_in   (addr_in),
    .bank_in   (bank_in),
    .byte_mask (byte_mask),
    .burst_on  (burst_on),
    .wr_slot   (wr_slot),
    .wr_en     (wr_en),
    .wr_bank   (wr_bank),
    .wr_col    (wr_col),
    .pre_req   (pre_req),
    .pre_bank  (pre_bank)
);

// File: tb/sdwr_burst_engine_bench.sv
`timescale 1ns/1ps
module sdwr_burst_engine_bench;

    localparam int MAXCYC = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1, rowstb_n = 1'b1, colstb_n = 1'b1, wrstb_n = 1'b1;
    logic [11:0] addr_in = '0;
    logic [1:0]  bank_in = '0;
    logic [15:0] din = '0;
    logic [1:0]  byte_mask = '0;

    logic       s0, s1, p0, p1;
    logic [1:0] en0, en1, b0, b1, pb0, pb1;
    logic [7:0] c0, c1;
    logic [15:0] d0, d1;

    int n_total = 0;
    int n_bad   = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    sdwr_burst_engine #(.BURST_CODE(2)) u_sdwr_burst_engine (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rowstb_n(rowstb_n),
        .colstb_n(colstb_n), .wrstb_n(wrstb_n), .addr_in(addr_in),
        .bank_in(bank_in), .din(din), .byte_mask(byte_mask),
        .wr_slot(s0), .wr_en(en0), .wr_bank(b0), .wr_col(c0),
        .wr_data(d0), .pre_req(p0), .pre_bank(pb0));

    sdwr_burst_engine #(.BURST_CODE(4)) u_sdwr_burst_engine_page (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rowstb_n(rowstb_n),
        .colstb_n(colstb_n), .wrstb_n(wrstb_n), .addr_in(addr_in),
        .bank_in(bank_in), .din(din), .byte_mask(byte_mask),
        .wr_slot(s1), .wr_en(en1), .wr_bank(b1), .wr_col(c1),
        .wr_data(d1), .pre_req(p1), .pre_bank(pb1));

    // reference state: index 0 = burst of 4, index 1 = full page
    int    bl_of[2]  = '{4, 256};
    bit    m_act[2];
    int    m_col[2], m_bank[2], m_left[2];
    bit    m_ap[2];
    bit    e_slot[2], e_pre[2], e_masked[2];
    logic [1:0]  e_en[2];
    int    e_col[2], e_bank[2], e_pbank[2];
    logic [15:0] e_data[2];
    string e_tag[2];

    function automatic int step_col(int k, int c);
        if (k == 1) return (c + 1) % 256;
        return (c & ~(bl_of[k] - 1)) | ((c + 1) & (bl_of[k] - 1));
    endfunction

    task automatic model_step(int k);
        int kind;
        e_slot[k] = 0; e_pre[k] = 0; e_en[k] = 2'b00; e_masked[k] = 0;
        if (!rst_n) begin
            m_act[k] = 0; e_tag[k] = "R1";
            return;
        end
        if (sel_n) kind = 0;
        else if ({rowstb_n, colstb_n, wrstb_n} == 3'b100) kind = 2;
        else if ({rowstb_n, colstb_n, wrstb_n} == 3'b111) kind = 1;
        else kind = 3;
        if (kind == 2) begin
            e_tag[k]  = m_act[k] ? "R8" : "R3";
            e_slot[k] = 1; e_col[k] = int'(addr_in[7:0]); e_bank[k] = int'(bank_in);
            e_data[k] = din; e_en[k] = ~byte_mask; e_masked[k] = (byte_mask != 0);
            m_ap[k]   = addr_in[10]; m_bank[k] = int'(bank_in);
            m_col[k]  = step_col(k, e_col[k]);
            m_act[k]  = (k == 1) || (bl_of[k] > 1);
            m_left[k] = bl_of[k] - 1;
        end else if (kind == 3) begin
            m_act[k] = 0; e_tag[k] = "R9";
        end else if (m_act[k]) begin
            e_tag[k]  = (k == 1) ? "R7" : ((kind == 0) ? "R2" : "R4");
            e_slot[k] = 1; e_col[k] = m_col[k]; e_bank[k] = m_bank[k];
            e_data[k] = din; e_en[k] = ~byte_mask; e_masked[k] = (byte_mask != 0);
            m_col[k]  = step_col(k, m_col[k]);
            if (k == 0) begin
                m_left[k]--;
                if (m_left[k] == 0) begin
                    m_act[k] = 0;
                    if (m_ap[k]) begin e_pre[k] = 1; e_pbank[k] = m_bank[k]; end
                end
            end
        end else begin
            e_tag[k] = "R5";
        end
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        n_total++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(int k, logic s, logic [1:0] en, logic [7:0] c, logic [1:0] b,
                           logic [15:0] dd, logic p, logic [1:0] pb);
        chk(e_tag[k], "slot", int'(s), int'(e_slot[k]));
        chk(e_masked[k] ? "R10" : e_tag[k], "enables", int'(en), int'(e_en[k]));
        chk("R6", "precharge", int'(p), int'(e_pre[k]));
        if (e_pre[k]) chk("R6", "precharge bank", int'(pb), e_pbank[k]);
        if (e_slot[k]) begin
            chk(e_tag[k], "column", int'(c), e_col[k]);
            chk(e_tag[k], "bank", int'(b), e_bank[k]);
            chk(e_tag[k], "data", int'(dd), int'(e_data[k]));
        end
    endtask

    task automatic tick();
        model_step(0);
        model_step(1);
        @(negedge clk);
        compare(0, s0, en0, c0, b0, d0, p0, pb0);
        compare(1, s1, en1, c1, b1, d1, p1, pb1);
    endtask

    // kind: 0 deselect, 1 NOP, 2 WRITE, 3 other command
    task automatic drive(int kind, int col, int bank, bit ap, logic [1:0] mask);
        logic [2:0] others[6] = '{3'b110, 3'b011, 3'b010, 3'b001, 3'b101, 3'b000};
        sel_n = (kind == 0);
        case (kind)
            2:       {rowstb_n, colstb_n, wrstb_n} = 3'b100;
            3:       {rowstb_n, colstb_n, wrstb_n} = others[$urandom % 6];
            0:       {rowstb_n, colstb_n, wrstb_n} = 3'($urandom);
            default: {rowstb_n, colstb_n, wrstb_n} = 3'b111;
        endcase
        addr_in     = 12'($urandom);
        addr_in[7:0] = 8'(col);
        addr_in[10] = ap;
        bank_in     = 2'(bank);
        byte_mask   = mask;
        din         = 16'($urandom);
    endtask

    initial begin
        void'($urandom(32'h1234_5EED));
        // R1: reset state
        rst_n = 0; drive(1, 0, 0, 0, 0);
        repeat (3) tick();
        rst_n = 1;
        repeat (2) tick();                                  // R5 idle
        drive(2, 6, 1, 1, 0); tick();                       // R3, R6 with wrap (R4)
        repeat (5) begin drive(1, 0, 0, 0, 0); tick(); end
        drive(2, 0, 2, 0, 0); tick();
        drive(1, 0, 0, 0, 0); tick();
        drive(2, 12, 3, 1, 0); tick();                      // R8 truncation
        repeat (2) begin drive(1, 0, 0, 0, 0); tick(); end
        drive(3, 0, 0, 0, 0); tick();                       // R9 other command
        repeat (3) begin drive(1, 0, 0, 0, 0); tick(); end
        drive(2, 33, 0, 1, 2'b01); tick();                  // R10 mask, R2 deselect
        drive(0, 0, 0, 0, 2'b10); tick();
        drive(0, 0, 0, 0, 2'b11); tick();
        drive(1, 0, 0, 0, 0); tick();
        drive(1, 0, 0, 0, 0); tick();
        drive(2, 250, 1, 1, 0); tick();                     // R7 page wrap
        repeat (10) begin drive(1, 0, 0, 0, 0); tick(); end
        drive(3, 0, 0, 0, 0); tick();
        drive(2, 5, 2, 1, 0); tick();                       // R1 reset mid-burst
        rst_n = 0; drive(1, 0, 0, 0, 0); tick();
        rst_n = 1; tick(); tick();
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 100);
            rst_n = ($urandom % 300) != 0;
            drive((r < 25) ? 2 : (r < 75) ? 1 : (r < 85) ? 0 : 3,
                  int'($urandom % 256), int'($urandom % 4), 1'($urandom),
                  (($urandom % 4) == 0) ? 2'($urandom) : 2'b00);
            tick();
        end
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        #(20.0 * MAXCYC);
        if (!done) begin
            done = 1;
            n_total++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

endmodule